// File: doc/BRIEF.md
# System Control Coprocessor Register File

This block is the privileged register bank of a 32-bit processor's system-control coprocessor. The core reaches it with move-to and move-from requests. Each request carries a primary register number, a secondary field (CRm), two opcode fields, a user-mode flag, a write flag and write data. A combinational legality check decides whether the field combination is allowed. An illegal request is rejected in the same cycle. A legal read returns data in the same cycle, and a legal write commits at the next rising clock edge while the request strobe is high.

The bank has two halves, selected by whether opcode_2 is zero. The zero half holds the identity, control, translation base, domain, fault, process, debug-address and access-control words. The non-zero half holds the constant cache-type word and the auxiliary control word. When the primary register is 14 and opcode_2 is zero, four more debug words are chosen by CRm. Each register applies its own write mask and forced-one bits. Writes to the cache, TLB and lock-down operation registers are accepted, but they change nothing. A change of the big-endian control bit produces a one-cycle event pulse.

Top module: `scc_regfile`

## Requirements
- R1: Any valid request with the user-mode flag set is rejected (`rsp_reject` high in the same cycle). It returns zero read data and changes no state.
- R2: Any valid request whose opcode_1 is non-zero is rejected.
- R3: Primary registers 4, 11 and 12 are always rejected. Registers 0 and 1 need CRm = 0 and take any opcode_2. Registers 2, 3, 5, 6 and 13 need CRm = 0 and opcode_2 = 0. Register 15 needs CRm = 1 and opcode_2 = 0.
- R4: Register 7 accepts only these (opcode_2, CRm) pairs: (0,5) (0,6) (0,7) (1,5) (1,6) (1,10) (4,10) (5,2) (6,5). Register 8 accepts opcode_2 of 0 with CRm 5..7, or opcode_2 of 1 with CRm 5 or 6. Register 9 accepts CRm 0 or 1 with opcode_2 1 or 2. Register 10 accepts CRm 0 or 1 with opcode_2 = 4. Every other combination is rejected.
- R5: After reset, the following reads hold. Register 0 with opcode_2 = 0 reads 0x69050000. Register 0 with opcode_2 ≠ 0 reads 0x0B1AA1AA. Register 1 with opcode_2 = 0 reads 0x00000078. Every other register reads zero.
- R6: A write to the control word (register 1, opcode_2 = 0) stores (data AND 0x00003B87) OR 0x00000078.
- R7: `big_endian` always shows bit 7 of the stored control word. `endian_flip` is high for exactly the one cycle after a control write edge that changed bit 7, and is low otherwise.
- R8: These write masks apply: register 2 uses 0xFFFFC000, register 5 uses 0x000006FF, register 13 uses 0xFE000000, register 15 uses 0x00003FFF, and registers 3 and 6 take all 32 bits. The auxiliary word (register 1, opcode_2 ≠ 0) uses 0x00000033.
- R9: Writes to register 0 (either half) and to registers 7, 8 and 10 are ignored. A later read returns the unchanged value.
- R10: For register 14 with opcode_2 = 0, CRm values 3, 4, 8 and 9 each address a separate 32-bit debug word, and CRm 0 addresses the main entry. All five words are fully writable.
- R11: A read with opcode_2 ≠ 0 returns the non-zero half. That is the cache-type word for register 0, the auxiliary word for register 1, and zero for every other register. Writes with opcode_2 ≠ 0 to any register other than 1 change nothing.
- R12: `rsp_rdata` is zero whenever there is no legal valid read. A rejected request, including a rejected write, leaves all stored state and `big_endian` unchanged and raises no `endian_flip`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_user | input | 1 | Request issued in user mode |
| req_crn | input | 4 | Primary register number |
| req_crm | input | 4 | Secondary register field |
| req_op1 | input | 3 | opcode_1 field |
| req_op2 | input | 3 | opcode_2 field |
| req_wdata | input | 32 | Write data |
| rsp_reject | output | 1 | Request is illegal (combinational) |
| rsp_rdata | output | 32 | Read data for a legal read (combinational) |
| big_endian | output | 1 | Stored big-endian control bit |
| endian_flip | output | 1 | One-cycle pulse after the endian bit changes |

## Verification
The assertions assume two things about the request fields. First, they are stable and known from the falling edge until the next rising edge. Second, reset is held for at least one clock before the first request. The bench drives every request at the falling edge and keeps it for the whole cycle. It raises reset for three clocks before any traffic and only then lets the fields vary. The random phase biases opcode_1 and the user flag towards zero and CRm towards small values. This keeps enough legal accesses flowing while every illegal field combination still appears.

// File: rtl/scc_pkg.sv
// Shared constants and per-register write policy for the system control
// coprocessor register file. Assumes a 32-bit data path and 4-bit register
// numbers; policy functions are evaluated at elaboration per register index.
package scc_pkg;
    localparam int DW      = 32;
    localparam int RNW     = 4;
    localparam int OPW     = 3;
    localparam int NREG    = 1 << RNW;
    localparam int N_DBG   = 4;
    localparam int ENDIAN_BIT = 7;

    localparam logic [DW-1:0] ID_WORD    = 32'h6905_0000;
    localparam logic [DW-1:0] CTYPE_WORD = 32'h0B1A_A1AA;
    localparam logic [DW-1:0] CTRL_KEEP  = 32'h0000_3B87;
    localparam logic [DW-1:0] CTRL_ONES  = 32'h0000_0078;
    localparam logic [DW-1:0] AUX_KEEP   = 32'h0000_0033;

    // Bits a write may change in a main-half register; zero means read-only.
    function automatic logic [DW-1:0] main_keep(input int idx);
        case (idx)
            1:       return CTRL_KEEP;
            2:       return 32'hFFFF_C000;
            3, 6:    return 32'hFFFF_FFFF;
            5:       return 32'h0000_06FF;
            9:       return 32'h0000_0001;
            13:      return 32'hFE00_0000;
            14:      return 32'hFFFF_FFFF;
            15:      return 32'h0000_3FFF;
            default: return '0;
        endcase
    endfunction

    // Bits forced to one on every write of a main-half register.
    function automatic logic [DW-1:0] main_ones(input int idx);
        return (idx == 1) ? CTRL_ONES : '0;
    endfunction

    // Reset contents of a main-half register.
    function automatic logic [DW-1:0] main_init(input int idx);
        case (idx)
            0:       return ID_WORD;
            1:       return CTRL_ONES;
            default: return '0;
        endcase
    endfunction

    // CRm value that selects debug word k under primary register 14.
    function automatic logic [RNW-1:0] dbg_crm(input int k);
        case (k)
            0:       return 4'd3;
            1:       return 4'd4;
            2:       return 4'd8;
            default: return 4'd9;
        endcase
    endfunction
endpackage

// File: rtl/scc_access_check.sv
// Combinational legality decision for one coprocessor request.
// Assumes fields are stable for the whole cycle; has no state.
module scc_access_check
    import scc_pkg::*;
(
    input  logic           user_mode,
    input  logic [RNW-1:0] crn,
    input  logic [RNW-1:0] crm,
    input  logic [OPW-1:0] op1,
    input  logic [OPW-1:0] op2,
    output logic           legal
);
    logic table_ok;

    // Sparse per-register table of allowed (opcode_2, CRm) combinations.
    always_comb begin
        table_ok = 1'b0;
        case (crn)
            4'd0, 4'd1: table_ok = (crm == 4'd0);
            4'd2, 4'd3, 4'd5, 4'd6, 4'd13:
                table_ok = (crm == 4'd0) && (op2 == 3'd0);
            4'd7: begin
                case (op2)
                    3'd0:    table_ok = (crm >= 4'd5) && (crm <= 4'd7);
                    3'd1:    table_ok = (crm == 4'd5) || (crm == 4'd6) || (crm == 4'd10);
                    3'd4:    table_ok = (crm == 4'd10);
                    3'd5:    table_ok = (crm == 4'd2);
                    3'd6:    table_ok = (crm == 4'd5);
                    default: table_ok = 1'b0;
                endcase
            end
            4'd8: table_ok = (crm >= 4'd5) && (crm <= 4'd7) &&
                             ((op2 == 3'd0) || ((op2 == 3'd1) && (crm != 4'd7)));
            4'd9:  table_ok = (crm <= 4'd1) && ((op2 == 3'd1) || (op2 == 3'd2));
            4'd10: table_ok = (crm <= 4'd1) && (op2 == 3'd4);
            4'd14: table_ok = (op2 == 3'd0) &&
                              ((crm == 4'd0) || (crm == 4'd3) || (crm == 4'd4) ||
                               (crm == 4'd8) || (crm == 4'd9));
            4'd15: table_ok = (crm == 4'd1) && (op2 == 3'd0);
            default: table_ok = 1'b0;
        endcase
    end

    // Privilege and opcode_1 gate the table result.
    always_comb legal = table_ok && !user_mode && (op1 == '0);
endmodule

// File: rtl/scc_bank.sv
// Storage for both register halves and the debug words, with per-register
// masked writes and the combinational read selection.
// Assumes wr_en is asserted only for legal, valid write requests.
module scc_bank
    import scc_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [RNW-1:0] crn,
    input  logic [RNW-1:0] crm,
    input  logic [OPW-1:0] op2,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rd_data,
    output logic [DW-1:0]  ctrl_word
);
    logic [DW-1:0]    main_q [NREG];
    logic [DW-1:0]    dbg_q  [N_DBG];
    logic [N_DBG-1:0] dbg_hit;
    logic [DW-1:0]    aux_q;
    logic             half0;
    logic             any_dbg;

    always_comb half0   = (op2 == '0);
    always_comb any_dbg = |dbg_hit;

    // One entry per main-half register; read-only entries become constants.
    for (genvar i = 0; i < NREG; i++) begin : g_main
        logic [DW-1:0] q;
        if (main_keep(i) != '0) begin : g_rw
            // Masked write with forced ones when this entry is addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= main_init(i);
                else if (wr_en && half0 && (crn == RNW'(i)) && !(i == 14 && any_dbg))
                    q <= (wdata & main_keep(i)) | main_ones(i);
            end
        end else begin : g_ro
            assign q = main_init(i);
        end
        assign main_q[i] = q;
    end

    // Debug words addressed by CRm under primary register 14.
    for (genvar k = 0; k < N_DBG; k++) begin : g_dbg
        assign dbg_hit[k] = half0 && (crn == 4'd14) && (crm == dbg_crm(k));
        // Full-width write of the selected debug word.
        always_ff @(posedge clk) begin
            if (!rst_n)
                dbg_q[k] <= '0;
            else if (wr_en && dbg_hit[k])
                dbg_q[k] <= wdata;
        end
    end

    // Auxiliary control word in the non-zero half.
    always_ff @(posedge clk) begin
        if (!rst_n)
            aux_q <= '0;
        else if (wr_en && !half0 && (crn == 4'd1))
            aux_q <= wdata & AUX_KEEP;
    end

    // Read selection across halves and debug words.
    always_comb begin
        rd_data = '0;
        if (!half0) begin
            if (crn == 4'd0)      rd_data = CTYPE_WORD;
            else if (crn == 4'd1) rd_data = aux_q;
        end else if ((crn == 4'd15) && (crm != 4'd1)) begin
            rd_data = '0;
        end else if (any_dbg) begin
            for (int k = 0; k < N_DBG; k++)
                if (dbg_hit[k]) rd_data = dbg_q[k];
        end else begin
            rd_data = main_q[crn];
        end
    end

    assign ctrl_word = main_q[1];

    AST_CTRL_FIXED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_word[6:3] == 4'hF); // R6
    AST_AUX_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_q & ~AUX_KEEP) == '0); // R8
endmodule

// File: rtl/scc_endian.sv
// Generates the one-cycle endianness-change pulse.
// Assumes ctrl_commit marks a control-word write landing at the next edge.
module scc_endian
    import scc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_commit,
    input  logic new_bit,
    input  logic cur_bit,
    output logic flip
);
    // Register a pulse when a committing write changes the endian bit.
    always_ff @(posedge clk) begin
        if (!rst_n) flip <= 1'b0;
        else        flip <= ctrl_commit && (new_bit != cur_bit);
    end

    AST_FLIP_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        flip |-> (cur_bit != $past(cur_bit))); // R7
endmodule

// File: rtl/scc_regfile.sv
// System control coprocessor register file top: legality check, storage and
// endian event. Assumes request fields are held stable through each cycle.
module scc_regfile
    import scc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_user,
    input  logic [3:0]  req_crn,
    input  logic [3:0]  req_crm,
    input  logic [2:0]  req_op1,
    input  logic [2:0]  req_op2,
    input  logic [31:0] req_wdata,
    output logic        rsp_reject,
    output logic [31:0] rsp_rdata,
    output logic        big_endian,
    output logic        endian_flip
);
    logic          legal;
    logic          commit;
    logic [DW-1:0] bank_rd;
    logic [DW-1:0] ctrl_word;

    scc_access_check u_check (
        .user_mode (req_user),
        .crn       (req_crn),
        .crm       (req_crm),
        .op1       (req_op1),
        .op2       (req_op2),
        .legal     (legal)
    );

    // Response decode: reject, commit and gated read data.
    always_comb begin
        rsp_reject = req_valid && !legal;
        commit     = req_valid && req_write && legal;
        rsp_rdata  = (req_valid && !req_write && legal) ? bank_rd : '0;
    end

    scc_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (commit),
        .crn       (req_crn),
        .crm       (req_crm),
        .op2       (req_op2),
        .wdata     (req_wdata),
        .rd_data   (bank_rd),
        .ctrl_word (ctrl_word)
    );

    assign big_endian = ctrl_word[ENDIAN_BIT];

    scc_endian u_endian (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_commit (commit && (req_crn == 4'd1) && (req_op2 == '0)),
        .new_bit     (req_wdata[ENDIAN_BIT]),
        .cur_bit     (ctrl_word[ENDIAN_BIT]),
        .flip        (endian_flip)
    );

    AST_USER_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_user) |-> rsp_reject); // R1
    AST_OP1_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op1 != '0)) |-> rsp_reject); // R2
    AST_CLOSED_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ((req_crn == 4'd4) || (req_crn == 4'd11) || (req_crn == 4'd12)))
        |-> rsp_reject); // R3
    AST_REJECT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rsp_reject) |=> ($stable(big_endian) && !endian_flip)); // R12
endmodule

// File: tb/tb_scc_regfile.sv
module tb_scc_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
    logic [3:0]  req_crn = '0, req_crm = '0;
    logic [2:0]  req_op1 = '0, req_op2 = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_reject, big_endian, endian_flip;
    logic [31:0] rsp_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    scc_regfile dut (.*);

    // Behavioural reference state
    logic [31:0] m_main [16];
    logic [31:0] m_dbg  [16];
    logic [31:0] m_aux;
    bit          m_flip;
    int          pairs7 [9] = '{5, 6, 7, 21, 22, 26, 74, 82, 101};

    function automatic bit m_legal(bit u, int n, int m, int o1, int o2);
        if (u || o1 != 0) return 0;
        case (n)
            0, 1:  return m == 0;
            2, 3, 5, 6, 13: return (m == 0) && (o2 == 0);
            7: begin
                foreach (pairs7[i]) if (pairs7[i] == o2 * 16 + m) return 1;
                return 0;
            end
            8:  return (o2 == 0 && m >= 5 && m <= 7) || (o2 == 1 && (m == 5 || m == 6));
            9:  return (m <= 1) && (o2 == 1 || o2 == 2);
            10: return (m <= 1) && (o2 == 4);
            14: return (o2 == 0) && (m == 0 || m == 3 || m == 4 || m == 8 || m == 9);
            15: return (m == 1) && (o2 == 0);
            default: return 0;
        endcase
    endfunction

    function automatic bit is_dbg(int m);
        return m == 3 || m == 4 || m == 8 || m == 9;
    endfunction

    function automatic logic [31:0] m_read(int n, int m, int o2);
        if (o2 != 0) begin
            if (n == 0) return 32'h0B1AA1AA;
            if (n == 1) return m_aux;
            return 0;
        end
        if (n == 15 && m != 1) return 0;
        if (n == 14 && is_dbg(m)) return m_dbg[m];
        return m_main[n];
    endfunction

    function automatic string tag_of(bit u, int n, int m, int o1, int o2, bit w);
        if (u) return "R1";
        if (o1 != 0) return "R2";
        if (!m_legal(u, n, m, o1, o2)) return (n >= 7 && n <= 10) ? "R4" : "R3";
        if (o2 != 0) return "R11";
        case (n)
            0:  return w ? "R9" : "R5";
            1:  return "R6";
            7, 8: return "R9";
            14: return "R10";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        foreach (m_main[i]) m_main[i] = 0;
        foreach (m_dbg[i])  m_dbg[i]  = 0;
        m_main[0] = 32'h69050000;
        m_main[1] = 32'h00000078;
        m_aux  = 0;
        m_flip = 0;
    endtask

    task automatic step(bit v, bit w, bit u, int n, int m, int o1, int o2, logic [31:0] d);
        bit ok;
        string tg;
        logic [31:0] exp_rd;
        @(negedge clk);
        req_valid = v; req_write = w; req_user = u;
        req_crn = 4'(n); req_crm = 4'(m); req_op1 = 3'(o1); req_op2 = 3'(o2);
        req_wdata = d;
        #1;
        ok     = m_legal(u, n, m, o1, o2);
        tg     = tag_of(u, n, m, o1, o2, w);
        exp_rd = (v && !w && ok) ? m_read(n, m, o2) : 32'h0;
        chk(tg, "reject", {31'b0, rsp_reject}, {31'b0, v && !ok});
        chk((v && ok && !w) ? tg : "R12", "rdata", rsp_rdata, exp_rd);
        chk("R7", "big_endian", {31'b0, big_endian}, {31'b0, m_main[1][7]});
        chk("R7", "endian_flip", {31'b0, endian_flip}, {31'b0, m_flip});
        // Advance the reference to the state after this edge.
        m_flip = 0;
        if (v && w && ok) begin
            if (o2 != 0) begin
                if (n == 1) m_aux = d & 32'h33;
            end else begin
                case (n)
                    1: begin
                        m_flip = (d[7] != m_main[1][7]);
                        m_main[1] = (d & 32'h3B87) | 32'h78;
                    end
                    2:  m_main[2]  = d & 32'hFFFFC000;
                    3:  m_main[3]  = d;
                    5:  m_main[5]  = d & 32'h6FF;
                    6:  m_main[6]  = d;
                    13: m_main[13] = d & 32'hFE000000;
                    14: if (is_dbg(m)) m_dbg[m] = d; else m_main[14] = d;
                    15: m_main[15] = d & 32'h3FFF;
                    default: ;
                endcase
            end
        end
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // Reset contents (R5)
        step(1, 0, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 3, 0);
        step(1, 0, 0, 1, 0, 0, 0, 0);
        step(1, 0, 0, 2, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        // Privilege and opcode_1 (R1, R2)
        step(1, 0, 1, 0, 0, 0, 0, 0);
        step(1, 1, 1, 1, 0, 0, 0, 32'hFFFFFFFF);
        step(1, 0, 0, 0, 0, 1, 0, 0);
        step(1, 1, 0, 1, 0, 7, 0, 32'h80);
        // Table (R3, R4)
        step(1, 0, 0, 4, 0, 0, 0, 0);
        step(1, 0, 0, 11, 0, 0, 0, 0);
        step(1, 0, 0, 12, 0, 0, 0, 0);
        step(1, 0, 0, 0, 1, 0, 0, 0);
        step(1, 0, 0, 2, 0, 0, 1, 0);
        step(1, 0, 0, 15, 0, 0, 0, 0);
        step(1, 0, 0, 15, 1, 0, 0, 0);
        step(1, 0, 0, 7, 5, 0, 2, 0);
        step(1, 0, 0, 7, 10, 0, 4, 0);
        step(1, 0, 0, 7, 2, 0, 5, 0);
        step(1, 0, 0, 8, 7, 0, 1, 0);
        step(1, 0, 0, 8, 6, 0, 1, 0);
        step(1, 0, 0, 9, 1, 0, 1, 0);
        step(1, 0, 0, 9, 1, 0, 0, 0);
        step(1, 0, 0, 10, 0, 0, 4, 0);
        // Control word and endian pulse (R6, R7)
        step(1, 1, 0, 1, 0, 0, 0, 32'hFFFFFFFF);
        step(1, 0, 0, 1, 0, 0, 0, 0);
        step(1, 1, 0, 1, 0, 0, 0, 32'h80);
        step(1, 1, 0, 1, 0, 0, 0, 32'h0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 1, 0, 0, 0, 0);
        // Masks (R8) and alternate half (R11)
        for (int r = 2; r < 16; r++) begin
            step(1, 1, 0, r, (r == 15) ? 1 : 0, 0, 0, 32'hFFFFFFFF);
            step(1, 0, 0, r, (r == 15) ? 1 : 0, 0, 0, 0);
        end
        step(1, 1, 0, 1, 0, 0, 1, 32'hFFFFFFFF);
        step(1, 0, 0, 1, 0, 0, 2, 0);
        step(1, 1, 0, 9, 0, 0, 1, 32'hFFFFFFFF);
        step(1, 0, 0, 9, 0, 0, 1, 0);
        // Ignored writes (R9)
        step(1, 1, 0, 0, 0, 0, 0, 32'h12345678);
        step(1, 0, 0, 0, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0, 1, 32'h12345678);
        step(1, 0, 0, 0, 0, 0, 1, 0);
        step(1, 1, 0, 7, 5, 0, 0, 32'hFFFFFFFF);
        step(1, 0, 0, 7, 5, 0, 0, 0);
        step(1, 1, 0, 10, 0, 0, 4, 32'hFFFFFFFF);
        step(1, 0, 0, 10, 0, 0, 4, 0);
        // Debug words (R10)
        step(1, 1, 0, 14, 3, 0, 0, 32'hA0000003);
        step(1, 1, 0, 14, 4, 0, 0, 32'hA0000004);
        step(1, 1, 0, 14, 8, 0, 0, 32'hA0000008);
        step(1, 1, 0, 14, 9, 0, 0, 32'hA0000009);
        step(1, 1, 0, 14, 0, 0, 0, 32'hA0000000);
        foreach (pairs7[i]) begin
            step(1, 0, 0, 14, (i % 5 == 0) ? 0 : (i % 5 == 1) ? 3 : (i % 5 == 2) ? 4 :
                                 (i % 5 == 3) ? 8 : 9, 0, 0, 0);
        end
        // Rejected write leaves state (R12)
        step(1, 1, 1, 14, 3, 0, 0, 32'h0);
        step(1, 1, 0, 3, 0, 2, 0, 32'h0);
        step(1, 0, 0, 14, 3, 0, 0, 0);
        step(1, 0, 0, 3, 0, 0, 0, 0);
        // Random traffic
        for (int t = 0; t < 3000; t++) begin
            int rn, rm, o1, o2;
            bit rv, rw, ru;
            rv = ($urandom % 10) != 0;
            rw = $urandom % 2;
            ru = ($urandom % 10) == 0;
            rn = $urandom % 16;
            rm = ($urandom % 2) ? 0 : int'($urandom % 16);
            o1 = (($urandom % 10) == 0) ? int'(1 + $urandom % 7) : 0;
            o2 = ($urandom % 5 < 3) ? 0 : int'($urandom % 8);
            step(rv, rw, ru, rn, rm, o1, o2, $urandom);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule